// File: doc/BRIEF.md
# SPI Master Block Transfer Sequencer

This block is a register-programmed SPI master. Software writes a block length and a command word over a small register bus. Setting the go bit starts a transfer of a counted block of packets, each 1 to 32 bits long and sent most significant bit first. Each transmitted packet is taken from the head of an external transmit FIFO through a pop strobe. Each received packet is delivered to an external receive FIFO through a push strobe.

When the block ends, the go bit drops and a sticky ready flag rises in the status word. The status word also holds the number of packets processed. Software must clear the ready flag by writing a 1 to it before another transfer can start.

The serial clock is derived from the system clock by a programmable divider. Clock polarity and phase come from a 2-bit mode field. Four chip-select lines each have their own inactive level. The selected line either follows the transfer or is held at a software-written value.

Register map (word address on `bus_addr`):
- 0: command word
- 1: block length minus one
- 2: status
- 3: clock divider

Top module: `spi_seq`

## Requirements
- R1: After reset, the status reads 0 and the command reads 0x03C00007 (all inactive-level bits 1, packet length field 7). `spi_cs` is 4'b1111, `sclk` is 0, `mosi` is 1, and the block length reads 0.
- R2: A command write with bit 31 set starts a transfer only if the ready flag is clear and at least one of bit 12 (receive enable) or bit 11 (transmit enable) is set. Otherwise bit 31 reads back 0 and no clock edge is produced.
- R3: A transfer moves exactly (block length + 1) packets. When the ready flag (status bit 30) rises, status bits 15:0 equal block length + 1 and command bit 31 reads 0.
- R4: The ready flag stays set until a status write with bit 30 equal to 1. A status write with bit 30 equal to 0 leaves it set.
- R5: With transmit enabled, each packet pops `tx_data` once. The low (field+1) bits of `tx_data` are sent MSB first on `mosi`, where the field is command bits 4:0. With transmit disabled, no pop occurs.
- R6: Command bits 29:28 give the mode: bit 29 is the idle level of `sclk`, and bit 28 selects sampling on the trailing edge (1) or the leading edge (0). Data changes on the other edge.
- R7: With receive enabled, each packet gives one `rx_push` pulse with the received bits right-aligned in `rx_word`, MSB first as received. With transmit disabled, `mosi` stays 1 for the whole transfer.
- R8: Bits 25:22 give the inactive level of chip selects 3 to 0, and bits 27:26 pick the line. During a hardware-controlled transfer, the picked line is driven to the inverse of its inactive level. All other lines stay at their inactive level.
- R9: When bit 21 is set, the picked chip-select line follows command bit 20 instead of the transfer state.
- R10: Successive `sclk` edges are (divider + 1) system clocks apart, and packets follow each other without a gap.
- R11: A block length write above MAX_PKTS-1 stores MAX_PKTS-1 (63 by default).
- R12: While a transfer runs, writes to the command, block length and divider registers are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register word address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for `bus_addr` |
| tx_data | input | 32 | Head word of the transmit FIFO |
| tx_pop | output | 1 | Consumes `tx_data` at this clock edge |
| rx_push | output | 1 | `rx_word` holds a received packet |
| rx_word | output | 32 | Received packet, right-aligned |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| spi_cs | output | 4 | Chip-select lines |

## Verification
The bench plays an SPI slave. It checks every packet in all four modes, against FIFO data it owns, for lengths from 1 to 32 bits and blocks of 1 to 64 packets. It goes after the last packet of a block in trailing-edge mode, where the reload of the next word meets the final sample: a design that reloads too early would corrupt or duplicate the last bit. It also covers a go write while ready is still set, a go write with no enable, and register writes in the middle of a transfer. A design that lost the sticky handshake would restart, and one that accepted the mid-transfer writes would send the wrong packet count. Chip-select polarity, software chip-select control and block-length saturation are checked directly at the pins and at the readback.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;
    localparam int NCS       = 4;
    localparam int WORD_W    = 32;
    localparam logic [1:0] A_CMD  = 2'd0;
    localparam logic [1:0] A_BLK  = 2'd1;
    localparam logic [1:0] A_STAT = 2'd2;
    localparam logic [1:0] A_DIV  = 2'd3;

    typedef struct packed {
        logic           master;
        logic [1:0]     mode;
        logic [1:0]     sel;
        logic [NCS-1:0] inact;
        logic           sw_cs;
        logic           sw_val;
        logic           rx_en;
        logic           tx_en;
        logic [4:0]     len;
    } cfg_t;

    localparam cfg_t CFG_RESET = '{master: 1'b0, mode: 2'd0, sel: 2'd0,
                                   inact: '1, sw_cs: 1'b0, sw_val: 1'b0,
                                   rx_en: 1'b0, tx_en: 1'b0, len: 5'd7};
endpackage

// File: rtl/spi_seq_regs.sv
module spi_seq_regs
    import spi_seq_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int DIV_W    = 8,
    parameter int MAX_PKTS = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_we,
    input  logic [1:0]       bus_addr,
    input  logic [31:0]      bus_wdata,
    output logic [31:0]      bus_rdata,
    input  logic             done,
    input  logic [CNT_W-1:0] pkt_cnt,
    output cfg_t             cfg,
    output logic [DIV_W-1:0] div,
    output logic [CNT_W-1:0] blk,
    output logic             busy,
    output logic             start
);
    localparam logic [CNT_W-1:0] BLK_MAX = CNT_W'(MAX_PKTS - 1);

    typedef struct packed {
        cfg_t             cfg;
        logic [DIV_W-1:0] div;
        logic [CNT_W-1:0] blk;
        logic             go;
        logic             rdy;
        logic             start;
    } st_t;

    st_t q, d;
    logic [CNT_W-1:0] wblk;

    always_comb begin
        d       = q;
        d.start = 1'b0;
        wblk    = bus_wdata[CNT_W-1:0];
        if (bus_we) begin
            case (bus_addr)
                A_CMD: if (!q.go) begin
                    d.cfg.master = bus_wdata[30];
                    d.cfg.mode   = bus_wdata[29:28];
                    d.cfg.sel    = bus_wdata[27:26];
                    d.cfg.inact  = bus_wdata[25:22];
                    d.cfg.sw_cs  = bus_wdata[21];
                    d.cfg.sw_val = bus_wdata[20];
                    d.cfg.rx_en  = bus_wdata[12];
                    d.cfg.tx_en  = bus_wdata[11];
                    d.cfg.len    = bus_wdata[4:0];
                    if (bus_wdata[31] && !q.rdy && (bus_wdata[12] || bus_wdata[11])) begin
                        d.go    = 1'b1;
                        d.start = 1'b1;
                    end
                end
                A_BLK:  if (!q.go) d.blk = (wblk > BLK_MAX) ? BLK_MAX : wblk;
                A_STAT: if (bus_wdata[30]) d.rdy = 1'b0;
                default: if (!q.go) d.div = bus_wdata[DIV_W-1:0];
            endcase
        end
        if (done) begin
            d.go  = 1'b0;
            d.rdy = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.cfg   <= CFG_RESET;
            q.div   <= '0;
            q.blk   <= '0;
            q.go    <= 1'b0;
            q.rdy   <= 1'b0;
            q.start <= 1'b0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CMD:  bus_rdata = {q.go, q.cfg.master, q.cfg.mode, q.cfg.sel, q.cfg.inact,
                                 q.cfg.sw_cs, q.cfg.sw_val, 7'd0, q.cfg.rx_en, q.cfg.tx_en,
                                 6'd0, q.cfg.len};
            A_BLK:  bus_rdata[CNT_W-1:0] = q.blk;
            A_STAT: begin
                bus_rdata[30]          = q.rdy;
                bus_rdata[CNT_W-1:0]   = pkt_cnt;
            end
            default: bus_rdata[DIV_W-1:0] = q.div;
        endcase
    end

    assign cfg   = q.cfg;
    assign div   = q.div;
    assign blk   = q.blk;
    assign busy  = q.go;
    assign start = q.start;

    // R2: no transfer may begin while the ready flag is still set
    a_r2_ready_blocks_go: assert property (@(posedge clk) disable iff (!rst_n)
        q.rdy |=> !q.start);
    // R4: ready is sticky until a write of 1 to its bit
    a_r4_ready_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (q.rdy && !(bus_we && bus_addr == A_STAT && bus_wdata[30])) |=> q.rdy);
    // R3: when ready rises, the packet count equals the block length plus one
    a_r3_count_at_ready: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.rdy) |-> (pkt_cnt == CNT_W'(q.blk + 1'b1)));
endmodule

// File: rtl/spi_seq_clkgen.sv
module spi_seq_clkgen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } st_t;

    st_t q, d;

    always_comb begin
        tick = run && (q.cnt == div);
        d    = q;
        if (!run || tick) d.cnt = '0;
        else              d.cnt = q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R10: the divider count never passes the programmed half period
    a_r10_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (q.cnt <= div));
endmodule

// File: rtl/spi_seq_shifter.sv
module spi_seq_shifter
    import spi_seq_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             tick,
    input  cfg_t             cfg,
    input  logic [CNT_W-1:0] blk,
    input  logic [31:0]      tx_data,
    input  logic             miso,
    output logic             tx_pop,
    output logic             done,
    output logic             active,
    output logic [CNT_W-1:0] cnt,
    output logic             sclk,
    output logic             mosi,
    output logic             rx_push,
    output logic [31:0]      rx_word
);
    typedef struct packed {
        logic             active;
        logic [5:0]       edge_i;
        logic             sclk;
        logic [31:0]      txs;
        logic [31:0]      rxs;
        logic [CNT_W-1:0] cnt;
        logic             push;
        logic [31:0]      rword;
    } st_t;

    st_t q, d;
    logic        cpol, cpha, lead, samp, last;
    logic [31:0] mask, load_word;

    always_comb begin
        cpol      = cfg.mode[1];
        cpha      = cfg.mode[0];
        mask      = 32'hFFFF_FFFF >> (5'd31 - cfg.len);
        load_word = cfg.tx_en ? (tx_data << (5'd31 - cfg.len)) : '1;
        lead      = ~q.edge_i[0];
        samp      = lead ^ cpha;
        last      = (q.edge_i == {cfg.len, 1'b1});
        d         = q;
        d.push    = 1'b0;
        tx_pop    = 1'b0;
        done      = 1'b0;
        if (!q.active) begin
            d.sclk = cpol;
            if (start) begin
                d.active = 1'b1;
                d.edge_i = '0;
                d.cnt    = '0;
                d.rxs    = '0;
                d.txs    = load_word;
                tx_pop   = cfg.tx_en;
            end
        end else if (tick) begin
            d.sclk   = ~q.sclk;
            d.edge_i = q.edge_i + 1'b1;
            if (samp)
                d.rxs = {q.rxs[30:0], miso};
            else if (!(cpha && q.edge_i == '0))
                d.txs = {q.txs[30:0], 1'b1};
            if (last) begin
                d.cnt    = q.cnt + 1'b1;
                d.edge_i = '0;
                if (cfg.rx_en) begin
                    d.push  = 1'b1;
                    d.rword = d.rxs & mask;
                end
                if (q.cnt == blk) begin
                    d.active = 1'b0;
                    done     = 1'b1;
                end else begin
                    d.txs  = load_word;
                    tx_pop = cfg.tx_en;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.active <= 1'b0;
            q.edge_i <= '0;
            q.sclk   <= 1'b0;
            q.txs    <= '1;
            q.rxs    <= '0;
            q.cnt    <= '0;
            q.push   <= 1'b0;
            q.rword  <= '0;
        end else begin
            q <= d;
        end
    end

    assign active  = q.active;
    assign cnt     = q.cnt;
    assign sclk    = q.sclk;
    assign mosi    = q.active ? q.txs[31] : 1'b1;
    assign rx_push = q.push;
    assign rx_word = q.rword;

    // R3: the packet counter never passes the programmed block length
    a_r3_count_in_block: assert property (@(posedge clk) disable iff (!rst_n)
        q.active |-> (q.cnt <= blk));
    // R5: packets take at least two clock edges, so pops never come back to back
    a_r5_pop_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |=> !tx_pop);
    // R10: the serial clock moves only on a divider tick
    a_r10_sclk_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (q.active && !tick) |=> $stable(q.sclk));
endmodule

// File: rtl/spi_seq_cs.sv
module spi_seq_cs
    import spi_seq_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  cfg_t           cfg,
    input  logic           busy,
    output logic [NCS-1:0] spi_cs
);
    typedef struct packed {
        logic [NCS-1:0] cs;
        logic [NCS-1:0] inact;
    } st_t;

    st_t q, d;
    logic [NCS-1:0] cs_next;

    for (genvar i = 0; i < NCS; i++) begin : g_line
        always_comb begin
            if (cfg.sel != i[1:0])
                cs_next[i] = cfg.inact[i];
            else if (cfg.sw_cs)
                cs_next[i] = cfg.sw_val;
            else
                cs_next[i] = busy ? ~cfg.inact[i] : cfg.inact[i];
        end
    end

    always_comb begin
        d.cs    = cs_next;
        d.inact = cfg.inact;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.cs    <= '1;
            q.inact <= '1;
        end else begin
            q <= d;
        end
    end

    assign spi_cs = q.cs;

    // R8: at most one line ever differs from its inactive level
    a_r8_single_active: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(q.cs ^ q.inact));
endmodule

// File: rtl/spi_seq.sv
module spi_seq
    import spi_seq_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int DIV_W    = 8,
    parameter int MAX_PKTS = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_we,
    input  logic [1:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic [31:0] tx_data,
    output logic        tx_pop,
    output logic        rx_push,
    output logic [31:0] rx_word,
    output logic        sclk,
    output logic        mosi,
    input  logic        miso,
    output logic [3:0]  spi_cs
);
    cfg_t             cfg;
    logic [DIV_W-1:0] div;
    logic [CNT_W-1:0] blk, pkt_cnt;
    logic             busy, start, done, active, tick;

    spi_seq_regs #(.CNT_W(CNT_W), .DIV_W(DIV_W), .MAX_PKTS(MAX_PKTS)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .done(done),
        .pkt_cnt(pkt_cnt), .cfg(cfg), .div(div), .blk(blk), .busy(busy),
        .start(start));

    spi_seq_clkgen #(.DIV_W(DIV_W)) u_clkgen (
        .clk(clk), .rst_n(rst_n), .run(active), .div(div), .tick(tick));

    spi_seq_shifter #(.CNT_W(CNT_W)) u_shifter (
        .clk(clk), .rst_n(rst_n), .start(start), .tick(tick), .cfg(cfg),
        .blk(blk), .tx_data(tx_data), .miso(miso), .tx_pop(tx_pop),
        .done(done), .active(active), .cnt(pkt_cnt), .sclk(sclk),
        .mosi(mosi), .rx_push(rx_push), .rx_word(rx_word));

    spi_seq_cs u_cs (
        .clk(clk), .rst_n(rst_n), .cfg(cfg), .busy(busy), .spi_cs(spi_cs));
endmodule

// File: tb/test_spi_seq.sv
module test_spi_seq;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = '0, bus_rdata, tx_data, rx_word;
    logic        tx_pop, rx_push, sclk, mosi, miso = 1'b1;
    logic [3:0]  spi_cs;

    spi_seq i_spi_seq (.clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_data(tx_data), .tx_pop(tx_pop),
        .rx_push(rx_push), .rx_word(rx_word), .sclk(sclk), .mosi(mosi), .miso(miso),
        .spi_cs(spi_cs));

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0, n_bad = 0;
    logic [31:0] tx_mem [64];
    int tx_idx = 0;
    logic [31:0] slv_base;
    assign tx_data = tx_mem[tx_idx[5:0]];
    always @(posedge clk) if (tx_pop) tx_idx <= tx_idx + 1;

    // monitor / slave model state
    bit mon_on = 0;
    int cur_len, cur_div, cur_sel;
    bit cur_cpol, cur_cpha, cur_sw, cur_swv;
    logic [3:0] cur_inact;
    logic prev_sclk, prev_mosi;
    int cyc = 0, last_edge, samp_n, pk, rx_n, gap_bad, cs_bad, edges;
    bit first_edge;
    logic [31:0] mosi_acc, mon_mask;
    logic [31:0] mon_mosi [64];
    logic [31:0] rx_got [64];

    function automatic logic [31:0] slv(int k);
        return (32'(k) * 32'h9E37_79B1) ^ slv_base;
    endfunction

    function automatic logic [31:0] mk_cmd(bit go, int mode, int sel, logic [3:0] inact,
                                           bit sw, bit swv, bit rx, bit tx, int len);
        return {go, 1'b1, 2'(mode), 2'(sel), inact, sw, swv, 7'd0, rx, tx, 6'd0, 5'(len)};
    endfunction

    function automatic logic [3:0] exp_cs(logic [3:0] inact, int sel, bit sw, bit swv, bit act);
        logic [3:0] r = inact;
        if (sw) r[sel] = swv;
        else if (act) r[sel] = ~inact[sel];
        return r;
    endfunction

    always @(negedge clk) begin
        cyc++;
        if (mon_on && sclk !== prev_sclk) begin
            edges++;
            if (!first_edge && (cyc - last_edge) != cur_div + 1) gap_bad++;
            first_edge = 0;
            last_edge  = cyc;
            if (spi_cs !== exp_cs(cur_inact, cur_sel, cur_sw, cur_swv, 1'b1)) cs_bad++;
            if ((sclk != cur_cpol) ^ cur_cpha) begin
                mosi_acc = {mosi_acc[30:0], prev_mosi};
                samp_n++;
                if (samp_n == cur_len + 1) begin
                    if (pk < 64) mon_mosi[pk] = mosi_acc & mon_mask;
                    pk++;
                    samp_n = 0;
                    miso = slv(pk)[cur_len];
                end else begin
                    miso = slv(pk)[cur_len - samp_n];
                end
            end
        end
        if (mon_on && rx_push) begin
            if (rx_n < 64) rx_got[rx_n] = rx_word;
            rx_n++;
        end
        prev_sclk = sclk;
        prev_mosi = mosi;
    end

    task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    task automatic bus_wr(logic [1:0] a, logic [31:0] v);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic bus_rd(logic [1:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    task automatic wait_rdy(output bit ok);
        logic [31:0] s;
        ok = 0;
        for (int i = 0; i < 20000; i++) begin
            bus_rd(2'd2, s);
            if (s[30]) begin ok = 1; break; end
        end
    endtask

    task automatic run_xfer(int mode, int len, int blk, int div, int sel, logic [3:0] inact,
                            bit rxen, bit txen, bit mid_write, bit keep_rdy);
        logic [31:0] cmd, v, mask;
        bit ok;
        int bad;
        mask = 32'hFFFF_FFFF >> (31 - len);
        for (int k = 0; k < 64; k++) tx_mem[k] = $urandom;
        slv_base = $urandom;
        bus_wr(2'd3, 32'(div));
        bus_wr(2'd1, 32'(blk));
        cmd = mk_cmd(0, mode, sel, inact, 0, 0, rxen, txen, len);
        bus_wr(2'd0, cmd);
        repeat (2) @(negedge clk);
        check(sclk == mode[1], "R6", "idle sclk level", 32'(sclk), 32'(mode[1]));
        check(spi_cs == inact, "R8", "idle chip selects", 32'(spi_cs), 32'(inact));
        cur_len = len; cur_div = div; cur_sel = sel; cur_inact = inact;
        cur_cpol = mode[1]; cur_cpha = mode[0]; cur_sw = 0; cur_swv = 0;
        mon_mask = mask; samp_n = 0; pk = 0; rx_n = 0; gap_bad = 0; cs_bad = 0;
        edges = 0; first_edge = 1; tx_idx = 0;
        miso = slv(0)[len];
        prev_sclk = sclk;
        mon_on = 1;
        bus_wr(2'd0, cmd | 32'h8000_0000);
        if (mid_write) begin
            repeat (3) @(negedge clk);
            bus_wr(2'd1, 32'(blk ^ 5));
            bus_wr(2'd3, 32'(div + 3));
            bus_wr(2'd0, mk_cmd(0, mode ^ 3, sel ^ 1, ~inact, 0, 0, 1, 1, len ^ 3));
        end
        wait_rdy(ok);
        repeat (2) @(negedge clk);
        mon_on = 0;
        check(ok, "R3", "ready flag reached", 32'(ok), 1);
        bus_rd(2'd2, v);
        check(v[15:0] == 16'(blk + 1), "R3", "status packet count", 32'(v[15:0]), 32'(blk + 1));
        bus_rd(2'd0, v);
        check(v[31] == 1'b0, "R3", "go bit cleared", 32'(v[31]), 0);
        if (mid_write) begin
            check(v == cmd, "R12", "command unchanged after mid write", v, cmd);
            bus_rd(2'd1, v);
            check(v == 32'(blk), "R12", "block length unchanged", v, 32'(blk));
            check(gap_bad == 0, "R12", "divider unchanged (edge gap errors)", 32'(gap_bad), 0);
        end
        check(edges == 2 * (len + 1) * (blk + 1), "R10", "sclk edge count", 32'(edges),
              32'(2 * (len + 1) * (blk + 1)));
        check(gap_bad == 0, "R10", "edge spacing errors", 32'(gap_bad), 0);
        check(cs_bad == 0, "R8", "chip select errors during transfer", 32'(cs_bad), 0);
        check(tx_idx == (txen ? blk + 1 : 0), "R5", "pop count", 32'(tx_idx), 32'(txen ? blk + 1 : 0));
        bad = -1;
        for (int k = 0; k <= blk; k++) begin
            v = txen ? (tx_mem[k] & mask) : mask;
            if (bad < 0 && mon_mosi[k] !== v) bad = k;
        end
        if (bad < 0) check(1, "R5", "mosi packets", 0, 0);
        else check(0, txen ? "R5" : "R7", "mosi packet", mon_mosi[bad],
                   txen ? (tx_mem[bad] & mask) : mask);
        check(rx_n == (rxen ? blk + 1 : 0), "R7", "push count", 32'(rx_n), 32'(rxen ? blk + 1 : 0));
        if (rxen) begin
            bad = -1;
            for (int k = 0; k <= blk; k++)
                if (bad < 0 && rx_got[k] !== (slv(k) & mask)) bad = k;
            if (bad < 0) check(1, "R7", "received packets", 0, 0);
            else check(0, "R7", "received packet", rx_got[bad], slv(bad) & mask);
        end
        check(sclk == mode[1], "R6", "sclk back at idle level", 32'(sclk), 32'(mode[1]));
        if (!keep_rdy) begin
            bus_wr(2'd2, 32'h4000_0000);
            bus_rd(2'd2, v);
            check(v[30] == 1'b0, "R4", "ready cleared by writing 1", 32'(v[30]), 0);
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", WATCHDOG);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v, s0;
        logic sc0;
        void'($urandom(32'd20240611));
        for (int k = 0; k < 64; k++) tx_mem[k] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        bus_rd(2'd2, v); check(v == 0, "R1", "reset status", v, 0);
        bus_rd(2'd0, v); check(v == 32'h03C0_0007, "R1", "reset command", v, 32'h03C0_0007);
        bus_rd(2'd1, v); check(v == 0, "R1", "reset block length", v, 0);
        check(spi_cs == 4'hF, "R1", "reset chip selects", 32'(spi_cs), 32'hF);
        check(sclk == 1'b0 && mosi == 1'b1, "R1", "reset sclk/mosi", {30'd0, sclk, mosi}, 32'h1);
        // R11 saturation
        bus_wr(2'd1, 32'd200); bus_rd(2'd1, v);
        check(v == 32'd63, "R11", "block length saturates", v, 63);
        bus_wr(2'd1, 32'd10); bus_rd(2'd1, v);
        check(v == 32'd10, "R11", "block length in range", v, 10);
        // R2 go without any enable
        sc0 = sclk;
        bus_wr(2'd0, mk_cmd(1, 1, 0, 4'hF, 0, 0, 0, 0, 7));
        bus_rd(2'd0, v); check(v[31] == 1'b0, "R2", "go without enable ignored", 32'(v[31]), 0);
        repeat (20) @(negedge clk);
        check(sclk == sc0 && spi_cs == 4'hF, "R2", "no activity without enable",
              {27'd0, spi_cs, sclk}, {27'd0, 4'hF, sc0});
        // directed transfers
        run_xfer(0, 7, 3, 1, 0, 4'hF, 1, 1, 0, 1);
        // R4: writing 0 to the ready bit keeps it
        bus_wr(2'd2, 32'h0000_0000); bus_rd(2'd2, s0);
        check(s0[30] == 1'b1, "R4", "ready kept by write of 0", 32'(s0[30]), 1);
        // R2: go while ready set is ignored
        sc0 = sclk;
        bus_wr(2'd0, mk_cmd(1, 0, 0, 4'hF, 0, 0, 1, 1, 7));
        bus_rd(2'd0, v); check(v[31] == 1'b0, "R2", "go while ready ignored", 32'(v[31]), 0);
        repeat (20) @(negedge clk);
        bus_rd(2'd2, v);
        check(v == s0 && sclk == sc0, "R2", "no restart while ready", v, s0);
        bus_wr(2'd2, 32'h4000_0000);
        run_xfer(3, 15, 2, 2, 1, 4'b0101, 1, 0, 0, 0);   // R7 receive only
        run_xfer(1, 31, 1, 0, 3, 4'b1010, 1, 1, 0, 0);   // 32-bit packets
        run_xfer(2, 0, 4, 0, 2, 4'hF, 1, 1, 0, 0);       // 1-bit packets
        run_xfer(1, 9, 5, 1, 2, 4'b0011, 1, 1, 1, 0);    // R12 mid-transfer writes
        run_xfer(0, 7, 63, 0, 0, 4'hF, 1, 1, 0, 0);      // full 64-packet block
        // R9 software chip select
        bus_wr(2'd0, mk_cmd(0, 0, 2, 4'hF, 1, 0, 0, 0, 7));
        repeat (2) @(negedge clk);
        check(spi_cs == 4'b1011, "R9", "software select low", 32'(spi_cs), 32'hB);
        bus_wr(2'd0, mk_cmd(0, 0, 2, 4'hF, 1, 1, 0, 0, 7));
        repeat (2) @(negedge clk);
        check(spi_cs == 4'b1111, "R9", "software select high", 32'(spi_cs), 32'hF);
        bus_wr(2'd0, mk_cmd(0, 0, 1, 4'b0101, 0, 0, 0, 0, 7));
        repeat (2) @(negedge clk);
        check(spi_cs == 4'b0101, "R8", "idle per-line polarity", 32'(spi_cs), 32'h5);
        // constrained random
        for (int t = 0; t < 16; t++) begin
            int m = int'($urandom_range(3, 0));
            int l = int'($urandom_range(31, 0));
            int b = int'($urandom_range(7, 0));
            int dv = int'($urandom_range(3, 0));
            int sl = int'($urandom_range(3, 0));
            logic [3:0] ia = 4'($urandom);
            int en = int'($urandom_range(3, 1));
            run_xfer(m, l, b, dv, sl, ia, en[0], en[1], 0, 0);
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule